// File: doc/BRIEF.md
# Alarm, Timer and Interrupt Controller for a Real-Time Clock

This block sits beside the counter chain of a real-time clock. Each cycle it compares a bank of alarm bytes with the live time and date counters. It runs a two-digit BCD timer that steps on a chosen unit-rollover tick. It also keeps two sticky flags, one for alarms and one for timer overflow.

From those flags and their enables it drives an active-low, open-drain style interrupt request. When alarms are switched off, the same pin carries a 1 Hz calibration square wave instead.

The counter chain supplies the counter bytes and one-cycle rollover ticks for hundredths, seconds, minutes, hours and days. Software supplies the alarm control byte, the alarm bytes, timer loads and flag-clear strobes.

Top module: `rtc_alarm_irq`

## Requirements
- R1: While reset is asserted and right after it, `tmr_q` is 00, both flags are 0 and `int_n` is 1.
- R2: With `alarm_en` = 0, no clock match sets `alm_flag`. In that state `int_n` shows a square wave that starts high and inverts after every 50 `tick_centi` pulses.
- R3: In dated mode (`acr[5:4]` = 11), the following fields must match bit for bit: hundredths, seconds, minutes, hours, bits 5:0 of the year/date byte and bits 4:0 of the weekday/month byte. Year bits 7:6 and weekday bits 7:5 are ignored.
- R4: In daily mode (`acr[5:4]` = 01), only hundredths, seconds, minutes and hours are compared. The date and month bytes do not take part.
- R5: In weekday mode (`acr[5:4]` = 10), the time fields must match. In addition, bit N of `al_wmon` must be set, where N is the counter weekday in `cnt_wmon[7:5]`.
- R6: All 8 bits of the hours byte are compared, so the 12-hour format bit (7) and the AM/PM bit (6) must be equal for a match.
- R7: `alm_flag` is set once on the cycle a match appears. It stays set until `flag_clr[1]` is pulsed. It is not set again while the same match persists.
- R8: The timer steps in BCD on the tick chosen by `acr[2:0]`: 1 hundredths, 2 seconds, 3 minutes, 4 hours, 5 days, and any other code holds. With `alarm_en` = 0 it steps on `tick_day`.
- R9: A step from 99 wraps the timer to 00 and sets `tmr_flag`. `tmr_flag` stays set until `flag_clr[0]` is pulsed.
- R10: With `acr[6]` = 1, the timer reaching the value `al_tmr` sets `alm_flag`.
- R11: With `alarm_en` = 1, `int_n` is 0 exactly when (`alm_flag` and `acr[7]`) or (`tmr_flag` and `acr[3]`) holds.
- R12: A pulse on `tmr_ld` loads `tmr_ld_val` into the timer and takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_en | input | 1 | Alarm enable from the control/status byte |
| acr | input | 8 | Alarm control byte |
| tick_centi | input | 1 | Hundredths rollover pulse |
| tick_sec | input | 1 | Seconds rollover pulse |
| tick_min | input | 1 | Minutes rollover pulse |
| tick_hour | input | 1 | Hours rollover pulse |
| tick_day | input | 1 | Day rollover pulse |
| cnt_centi | input | 8 | Hundredths counter (BCD) |
| cnt_sec | input | 8 | Seconds counter (BCD) |
| cnt_min | input | 8 | Minutes counter (BCD) |
| cnt_hour | input | 8 | Hours counter with format bits |
| cnt_ydate | input | 8 | Year (7:6) and date (5:0) |
| cnt_wmon | input | 8 | Weekday (7:5) and month (4:0) |
| al_centi | input | 8 | Alarm hundredths |
| al_sec | input | 8 | Alarm seconds |
| al_min | input | 8 | Alarm minutes |
| al_hour | input | 8 | Alarm hours |
| al_ydate | input | 8 | Alarm date byte |
| al_wmon | input | 8 | Alarm month byte, or weekday mask in weekday mode |
| al_tmr | input | 8 | Timer alarm value |
| tmr_ld | input | 1 | Timer load strobe |
| tmr_ld_val | input | 8 | Timer load value |
| flag_clr | input | 2 | Flag clear strobes: bit 0 timer flag, bit 1 alarm flag |
| tmr_q | output | 8 | Timer value (BCD) |
| tmr_flag | output | 1 | Timer overflow flag |
| alm_flag | output | 1 | Alarm flag |
| int_n | output | 1 | Interrupt pull-down enable, active low |

## Verification
The bench gives each mode a counter set that matches on every compared field but differs in the fields that mode ignores. A wrong field mask would therefore leave the flag low, or a too-loose mask would raise it too early.

It clears the alarm flag while the match is still present. A design that re-arms on level rather than on the match edge sets the flag again at once.

It loads 97 and steps the timer across 99. A plain binary increment, or a missing overflow flag, shows up as the wrong value after the wrap. Wrong-resolution ticks and a held code are applied to show the timer does not move.

The calibration wave is checked at the 49th and 50th hundredths tick. An off-by-one divider would invert on the wrong tick.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   typedef enum logic [1:0] {
      AM_OFF     = 2'b00,
      AM_DAILY   = 2'b01,
      AM_WEEKDAY = 2'b10,
      AM_DATED   = 2'b11
   } alarm_mode_e;

   localparam logic [7:0] BCD_TOP     = 8'h99;
   localparam logic [7:0] DATE_MASK   = 8'h3F;
   localparam logic [7:0] MONTH_MASK  = 8'h1F;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
   import rtc_alarm_pkg::*;
#(
   parameter int DW    = 8,
   parameter int WDAYS = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  alarm_mode_e   mode,
   input  logic          tmr_alarm_on,
   input  logic [DW-1:0] cnt_centi, cnt_sec, cnt_min, cnt_hour, cnt_ydate, cnt_wmon,
   input  logic [DW-1:0] al_centi, al_sec, al_min, al_hour, al_ydate, al_wmon,
   input  logic [DW-1:0] tmr_q,
   input  logic [DW-1:0] al_tmr,
   output logic          hit
);
   logic time_eq, date_eq, wday_ok, clk_now, clk_q, tmr_now, tmr_q_eq;
   logic [2:0] wd;

   assign wd      = cnt_wmon[DW-1 -: 3];
   assign time_eq = (cnt_centi == al_centi) && (cnt_sec == al_sec) &&
                    (cnt_min == al_min) && (cnt_hour == al_hour);
   assign date_eq = (((cnt_ydate ^ al_ydate) & DATE_MASK) == '0) &&
                    (((cnt_wmon ^ al_wmon) & MONTH_MASK) == '0);
   assign wday_ok = (int'(wd) < WDAYS) && al_wmon[wd];

   always_comb begin
      unique case (mode)
         AM_DAILY:   clk_now = active && time_eq;
         AM_WEEKDAY: clk_now = active && time_eq && wday_ok;
         AM_DATED:   clk_now = active && time_eq && date_eq;
         default:    clk_now = 1'b0;
      endcase
   end

   assign tmr_now = active && tmr_alarm_on && (tmr_q == al_tmr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q    <= 1'b0;
         tmr_q_eq <= 1'b0;
      end else begin
         clk_q    <= clk_now;
         tmr_q_eq <= tmr_now;
      end
   end

   assign hit = (clk_now && !clk_q) || (tmr_now && !tmr_q_eq);
endmodule

// File: rtl/rtc_bcd_timer.sv
module rtc_bcd_timer
   import rtc_alarm_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          ld,
   input  logic [DW-1:0] ld_val,
   output logic [DW-1:0] q,
   output logic          wrap
);
   assign wrap = step && !ld && (q == BCD_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (ld)   q <= ld_val;
      else if (wrap) q <= '0;
      else if (step) q <= bcd_inc(q);
   end
endmodule

// File: rtl/rtc_calib_wave.sv
module rtc_calib_wave #(
   parameter int HALF_TICKS = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic wave
);
   localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         wave <= 1'b1;
      end else if (tick) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            wave <= !wave;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
   import rtc_alarm_pkg::*;
#(
   parameter int DW         = 8,
   parameter int WDAYS      = 7,
   parameter int HALF_TICKS = 50,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alarm_en,
   input  logic [7:0]    acr,
   input  logic          tick_centi,
   input  logic          tick_sec,
   input  logic          tick_min,
   input  logic          tick_hour,
   input  logic          tick_day,
   input  logic [DW-1:0] cnt_centi,
   input  logic [DW-1:0] cnt_sec,
   input  logic [DW-1:0] cnt_min,
   input  logic [DW-1:0] cnt_hour,
   input  logic [DW-1:0] cnt_ydate,
   input  logic [DW-1:0] cnt_wmon,
   input  logic [DW-1:0] al_centi,
   input  logic [DW-1:0] al_sec,
   input  logic [DW-1:0] al_min,
   input  logic [DW-1:0] al_hour,
   input  logic [DW-1:0] al_ydate,
   input  logic [DW-1:0] al_wmon,
   input  logic [DW-1:0] al_tmr,
   input  logic          tmr_ld,
   input  logic [DW-1:0] tmr_ld_val,
   input  logic [1:0]    flag_clr,
   output logic [DW-1:0] tmr_q,
   output logic          tmr_flag,
   output logic          alm_flag,
   output logic          int_n
);
   if (DW != 8) begin : g_bad_dw
      $error("rtc_alarm_irq: DW must be 8 for BCD bytes");
   end
   if (WDAYS < 1 || WDAYS > 8) begin : g_bad_wdays
      $error("rtc_alarm_irq: WDAYS out of range");
   end
   if (HALF_TICKS < 2) begin : g_bad_half
      $error("rtc_alarm_irq: HALF_TICKS must be at least 2");
   end

   logic tmr_step, sel_step, wrap, hit, wave;
   logic irq_req;

   always_comb begin
      unique case (acr[2:0])
         3'd1:    sel_step = tick_centi;
         3'd2:    sel_step = tick_sec;
         3'd3:    sel_step = tick_min;
         3'd4:    sel_step = tick_hour;
         3'd5:    sel_step = tick_day;
         default: sel_step = 1'b0;
      endcase
   end
   assign tmr_step = alarm_en ? sel_step : tick_day;

   rtc_bcd_timer #(.DW(DW)) u_timer (
      .clk(clk), .rst_n(rst_n), .step(tmr_step), .ld(tmr_ld),
      .ld_val(tmr_ld_val), .q(tmr_q), .wrap(wrap)
   );

   rtc_alarm_match #(.DW(DW), .WDAYS(WDAYS)) u_match (
      .clk(clk), .rst_n(rst_n), .active(alarm_en),
      .mode(alarm_mode_e'(acr[5:4])), .tmr_alarm_on(acr[6]),
      .cnt_centi(cnt_centi), .cnt_sec(cnt_sec), .cnt_min(cnt_min),
      .cnt_hour(cnt_hour), .cnt_ydate(cnt_ydate), .cnt_wmon(cnt_wmon),
      .al_centi(al_centi), .al_sec(al_sec), .al_min(al_min),
      .al_hour(al_hour), .al_ydate(al_ydate), .al_wmon(al_wmon),
      .tmr_q(tmr_q), .al_tmr(al_tmr), .hit(hit)
   );

   rtc_calib_wave #(.HALF_TICKS(HALF_TICKS)) u_wave (
      .clk(clk), .rst_n(rst_n), .tick(tick_centi), .wave(wave)
   );

   if (SET_WINS) begin : g_set_wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tmr_flag <= 1'b0;
            alm_flag <= 1'b0;
         end else begin
            if (wrap)             tmr_flag <= 1'b1;
            else if (flag_clr[0]) tmr_flag <= 1'b0;
            if (hit)              alm_flag <= 1'b1;
            else if (flag_clr[1]) alm_flag <= 1'b0;
         end
      end
   end else begin : g_clr_wins
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tmr_flag <= 1'b0;
            alm_flag <= 1'b0;
         end else begin
            if (flag_clr[0]) tmr_flag <= 1'b0;
            else if (wrap)   tmr_flag <= 1'b1;
            if (flag_clr[1]) alm_flag <= 1'b0;
            else if (hit)    alm_flag <= 1'b1;
         end
      end
   end

   assign irq_req = (alm_flag && acr[7]) || (tmr_flag && acr[3]);
   assign int_n   = alarm_en ? !irq_req : wave;
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       alarm_en,
   input logic [7:0] acr,
   input logic       tmr_ld,
   input logic [1:0] flag_clr,
   input logic [7:0] tmr_q,
   input logic       tmr_flag,
   input logic       alm_flag,
   input logic       int_n
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (tmr_q == 8'h00 && !tmr_flag && !alm_flag && int_n));

   // R7
   alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_flag && !flag_clr[1]) |=> alm_flag);

   // R9
   timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_flag) |-> ($past(tmr_q) == 8'h99));

   // R8
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_en && acr[2:0] == 3'd0 && !tmr_ld) |=> $stable(tmr_q));

   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_en && !alm_flag && !tmr_flag) |-> int_n);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .acr(acr),
   .tmr_ld(tmr_ld), .flag_clr(flag_clr), .tmr_q(tmr_q),
   .tmr_flag(tmr_flag), .alm_flag(alm_flag), .int_n(int_n)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alarm_en = 1'b0;
   logic [7:0] acr = '0;
   logic tick_centi = 0, tick_sec = 0, tick_min = 0, tick_hour = 0, tick_day = 0;
   logic [7:0] cnt_centi = '0, cnt_sec = '0, cnt_min = '0, cnt_hour = '0;
   logic [7:0] cnt_ydate = '0, cnt_wmon = '0;
   logic [7:0] al_centi = '0, al_sec = '0, al_min = '0, al_hour = '0;
   logic [7:0] al_ydate = '0, al_wmon = '0, al_tmr = '0;
   logic tmr_ld = 1'b0;
   logic [7:0] tmr_ld_val = '0;
   logic [1:0] flag_clr = '0;
   logic [7:0] tmr_q;
   logic tmr_flag, alm_flag, int_n;
   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rtc_alarm_irq u_rtc_alarm_irq (.*);

   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_flags();
      flag_clr = 2'b11; step(); flag_clr = 2'b00; step();
   endtask

   task automatic pulse_centi(); tick_centi = 1; step(); tick_centi = 0; endtask
   task automatic pulse_sec();   tick_sec = 1;   step(); tick_sec = 0;   endtask
   task automatic pulse_day();   tick_day = 1;   step(); tick_day = 0;   endtask

   task automatic t_reset();
      rst_n = 0; step(2);
      check("R1 timer", tmr_q, 8'h00);
      check("R1 flags", {6'd0, alm_flag, tmr_flag}, 8'h00);
      check("R1 int_n", {7'd0, int_n}, 8'h01);
      rst_n = 1; step();
   endtask

   task automatic t_calib();
      cnt_centi = 8'h12; al_centi = 8'h12;
      acr = 8'h30; step(2);
      check("R2 no alarm while disabled", {7'd0, alm_flag}, 8'h00);
      for (int i = 0; i < 49; i++) pulse_centi();
      check("R2 wave high at 49", {7'd0, int_n}, 8'h01);
      pulse_centi();
      check("R2 wave low at 50", {7'd0, int_n}, 8'h00);
      for (int i = 0; i < 50; i++) pulse_centi();
      check("R2 wave high at 100", {7'd0, int_n}, 8'h01);
   endtask

   task automatic t_dated();
      alarm_en = 1; acr = 8'h30;
      cnt_centi = 8'h12; cnt_sec = 8'h34; cnt_min = 8'h56; cnt_hour = 8'h08;
      cnt_ydate = {2'b11, 6'h15}; cnt_wmon = {3'd3, 5'h06};
      al_centi = 8'h12; al_sec = 8'h35; al_min = 8'h56; al_hour = 8'h08;
      al_ydate = {2'b00, 6'h15}; al_wmon = {3'd0, 5'h06};
      step();
      check("R3 seconds differ", {7'd0, alm_flag}, 8'h00);
      al_sec = 8'h34; step();
      check("R3 dated match ignoring year/weekday", {7'd0, alm_flag}, 8'h01);
      check("R11 int_n masked", {7'd0, int_n}, 8'h01);
      step(3);
      check("R7 flag held", {7'd0, alm_flag}, 8'h01);
      flag_clr = 2'b10; step(); flag_clr = 2'b00; step(2);
      check("R7 no re-set on same match", {7'd0, alm_flag}, 8'h00);
   endtask

   task automatic t_daily();
      cnt_ydate = {2'b11, 6'h16}; step();
      check("R3 date differs", {7'd0, alm_flag}, 8'h00);
      acr = 8'h10; step();
      check("R4 daily ignores date", {7'd0, alm_flag}, 8'h01);
      clear_flags();
   endtask

   task automatic t_weekday();
      acr = 8'h20; al_wmon = 8'h08; cnt_wmon = {3'd2, 5'h06}; step();
      check("R5 weekday not in mask", {7'd0, alm_flag}, 8'h00);
      cnt_wmon = {3'd3, 5'h06}; step();
      check("R5 weekday in mask", {7'd0, alm_flag}, 8'h01);
      acr = 8'hA0; step();
      check("R11 alarm irq low", {7'd0, int_n}, 8'h00);
      clear_flags();
      check("R11 irq released", {7'd0, int_n}, 8'h01);
   endtask

   task automatic t_hours12();
      acr = 8'h10; cnt_sec = 8'h00; step();
      cnt_sec = 8'h34; cnt_hour = 8'hC5; al_hour = 8'h85; step();
      check("R6 AM/PM bit differs", {7'd0, alm_flag}, 8'h00);
      al_hour = 8'hC5; step();
      check("R6 12h hours match", {7'd0, alm_flag}, 8'h01);
      acr = 8'h00; clear_flags();
   endtask

   task automatic t_timer();
      acr = 8'h02; tmr_ld = 1; tmr_ld_val = 8'h97; tick_sec = 1; step();
      tmr_ld = 0; tick_sec = 0;
      check("R12 load beats step", tmr_q, 8'h97);
      pulse_centi();
      check("R8 other resolution ignored", tmr_q, 8'h97);
      pulse_sec(); check("R8 step to 98", tmr_q, 8'h98);
      pulse_sec(); check("R8 step to 99", tmr_q, 8'h99);
      check("R9 no flag before wrap", {7'd0, tmr_flag}, 8'h00);
      pulse_sec(); check("R9 wrap value", tmr_q, 8'h00);
      check("R9 wrap flag", {7'd0, tmr_flag}, 8'h01);
      acr = 8'h0A; step();
      check("R11 timer irq low", {7'd0, int_n}, 8'h00);
      acr = 8'h00; pulse_sec();
      check("R8 code 0 holds", tmr_q, 8'h00);
      check("R9 flag sticky", {7'd0, tmr_flag}, 8'h01);
      clear_flags();
      check("R9 flag cleared", {7'd0, tmr_flag}, 8'h00);
      tmr_ld = 1; tmr_ld_val = 8'h09; step(); tmr_ld = 0;
      acr = 8'h02; pulse_sec();
      check("R8 BCD carry", tmr_q, 8'h10);
   endtask

   task automatic t_tmr_alarm();
      acr = 8'h42; al_tmr = 8'h05;
      tmr_ld = 1; tmr_ld_val = 8'h03; step(); tmr_ld = 0;
      pulse_sec();
      check("R10 not yet equal", {7'd0, alm_flag}, 8'h00);
      pulse_sec(); step();
      check("R10 timer alarm", {7'd0, alm_flag}, 8'h01);
      acr = 8'h00; clear_flags();
   endtask

   task automatic t_days();
      alarm_en = 0; acr = 8'h02;
      tmr_ld = 1; tmr_ld_val = 8'h00; step(); tmr_ld = 0;
      pulse_sec();
      check("R8 disabled ignores seconds", tmr_q, 8'h00);
      pulse_day();
      check("R8 disabled counts days", tmr_q, 8'h01);
   endtask

   initial begin
      step(1);
      t_reset();
      t_calib();
      t_dated();
      t_daily();
      t_weekday();
      t_hours12();
      t_timer();
      t_tmr_alarm();
      t_days();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule